// File: doc/BRIEF.md
# Receive Byte Queue with Fill-Level Interrupt

This block sits between a serial receiver and the processor's read port. The receiver offers each completed byte on a one-cycle push strobe. The processor takes bytes from a read port that always shows the oldest stored byte. In queued mode (`fifo_en` high) the bytes go into a 16-entry first-in first-out store. An interrupt is raised while the number of stored bytes is at or above a level chosen by a 2-bit select.

In single-buffer mode (`fifo_en` low) the queue is held empty. A single holding register keeps the most recent byte, and a ready flag marks it as unread. In both modes an overrun flag records a byte that could not be stored. The flag stays set until the processor acknowledges it. A synchronous clear input flushes the queue without a full reset.

Top module: `rx_fifo_trig`

## Requirements
- R1: In queued mode, bytes are read in the order they were pushed. `rd_data` shows the oldest stored byte while `data_ready` is high, and is 0 when nothing is stored. A cycle with `rd_en` high removes that byte.
- R2: `fill_level` gives the number of stored bytes, from 0 to 16. It changes one clock edge after an accepted push or read. A push and a read in the same cycle leave it unchanged.
- R3: A push while 16 bytes are stored is discarded and the stored bytes are kept. This also sets `overrun`.
- R4: A read while the queue is empty changes nothing. `fill_level` stays 0, and later pushes and reads keep their order.
- R5: In queued mode, `irq` is high whenever `fill_level` is at or above the selected level, and it falls once reads bring the count below that level. `trig_sel` values 0, 1, 2 and 3 select 1, 4, 8 and 14 bytes. `irq` is never high without `data_ready`.
- R6: `fifo_clr` high at a clock edge empties the queue. After that edge `fill_level` is 0 and `irq` is low, even if a push arrives in the same cycle.
- R7: In single-buffer mode, a push loads the holding register and sets `data_ready`, `fill_level` becomes 1, and `rd_data` shows the byte. A read clears `data_ready`, and `irq` follows `data_ready`.
- R8: In single-buffer mode, a push while an unread byte is held, with no read in the same cycle, replaces the byte and sets `overrun`.
- R9: `overrun` stays set until a cycle with `ovr_rd` high clears it. If a new overrun happens in that same cycle, the flag stays set.
- R10: After a synchronous reset, `fill_level` is 0 and `data_ready`, `irq`, `overrun` and `rd_data` are all 0.
- R11: While `fifo_en` is low, the queue is kept empty. When queued mode is turned back on, it starts with 0 bytes stored.

Note on the select (R5): the four levels are 1 byte, a quarter of the depth, half of the depth, and the depth minus 2. For a depth of 16 these are 1, 4, 8 and 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 selects queued mode, 0 selects single-buffer mode |
| fifo_clr | input | 1 | Synchronous flush of the queue |
| trig_sel | input | 2 | Interrupt level select: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14 |
| push_valid | input | 1 | Receiver offers a completed byte |
| push_data | input | 8 | Byte offered by the receiver |
| rd_en | input | 1 | Processor takes the byte shown on rd_data |
| ovr_rd | input | 1 | Processor acknowledges and clears the overrun flag |
| rd_data | output | 8 | Oldest unread byte, or 0 when none is stored |
| data_ready | output | 1 | At least one unread byte is stored |
| fill_level | output | 5 | Number of stored bytes |
| irq | output | 1 | Receive interrupt |
| overrun | output | 1 | Sticky flag: a byte was lost |

## Verification
The bound checker watches, on every cycle, the properties that hold at any moment:
- the count never goes above the depth;
- a push into a full queue keeps the count at 16 and sets the overrun flag;
- a read of an empty queue leaves the count at zero;
- a flush leaves the queue empty with the interrupt low;
- the overrun flag stays set until it is acknowledged;
- the interrupt never appears without ready data;
- single-buffer mode never reports more than one byte.

Some behaviour only the bench scenarios can show: the byte order across a full fill and drain, the exact level at which each select value raises and drops the interrupt, and the replacement of the held byte in single-buffer mode. These need expected data values and known histories.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned RXQ_DW    = 8;
    localparam int unsigned RXQ_DEPTH = 16;

    typedef enum logic [1:0] {
        TRIG_ONE       = 2'd0,
        TRIG_QUARTER   = 2'd1,
        TRIG_HALF      = 2'd2,
        TRIG_NEAR_FULL = 2'd3
    } trig_sel_e;

    typedef struct packed {
        logic              valid;
        logic [RXQ_DW-1:0] data;
    } rx_beat_t;

    // Interrupt threshold in bytes for a given select and queue depth
    function automatic int unsigned trig_level(trig_sel_e sel, int unsigned depth);
        case (sel)
            TRIG_ONE:       return 1;
            TRIG_QUARTER:   return depth / 4;
            TRIG_HALF:      return depth / 2;
            default:        return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clr,
    input  rx_beat_t                       wr_beat,
    input  logic                           rd,
    output logic [RXQ_DW-1:0]              head,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           full
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    logic [RXQ_DW-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic              do_wr, do_rd;

    function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (count == CNT_W'(DEPTH));
    assign do_wr = wr_beat.valid && !full;
    assign do_rd = rd && (count != '0);
    assign head  = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr && !clr && !rst)
            mem[wp] <= wr_beat.data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_wr) wp <= step(wp);
            if (do_rd) rp <= step(rp);
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rxq_hold.sv
module rxq_hold
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  rx_beat_t          wr_beat,
    input  logic              rd,
    output logic [RXQ_DW-1:0] data,
    output logic              ready
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            data  <= '0;
            ready <= 1'b0;
        end else if (wr_beat.valid) begin
            data  <= wr_beat.data;
            ready <= 1'b1;
        end else if (rd) begin
            ready <= 1'b0;
        end
    end

endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH
) (
    input  logic                       enable,
    input  trig_sel_e                  sel,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       irq
);
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    logic [CNT_W-1:0] level;

    assign level = CNT_W'(trig_level(sel, DEPTH));
    assign irq   = enable && (count >= level);

endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       fifo_en,
    input  logic                       fifo_clr,
    input  logic [1:0]                 trig_sel,
    input  logic                       push_valid,
    input  logic [RXQ_DW-1:0]          push_data,
    input  logic                       rd_en,
    input  logic                       ovr_rd,
    output logic [RXQ_DW-1:0]          rd_data,
    output logic                       data_ready,
    output logic [$clog2(DEPTH+1)-1:0] fill_level,
    output logic                       irq,
    output logic                       overrun
);
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    rx_beat_t          q_beat, h_beat;
    logic [RXQ_DW-1:0] q_head, h_data;
    logic [CNT_W-1:0]  q_count;
    logic              q_full, h_ready, q_irq, ovr_set;

    assign q_beat = '{valid: push_valid && fifo_en,  data: push_data};
    assign h_beat = '{valid: push_valid && !fifo_en, data: push_data};

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clr     (fifo_clr || !fifo_en),
        .wr_beat (q_beat),
        .rd      (rd_en && fifo_en),
        .head    (q_head),
        .count   (q_count),
        .full    (q_full)
    );

    rxq_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .clr     (fifo_en),
        .wr_beat (h_beat),
        .rd      (rd_en && !fifo_en),
        .data    (h_data),
        .ready   (h_ready)
    );

    rxq_trigger #(.DEPTH(DEPTH)) u_trig (
        .enable (fifo_en),
        .sel    (trig_sel_e'(trig_sel)),
        .count  (q_count),
        .irq    (q_irq)
    );

    assign data_ready = fifo_en ? (q_count != '0) : h_ready;
    assign fill_level = fifo_en ? q_count : CNT_W'(h_ready);
    assign irq        = fifo_en ? q_irq : h_ready;
    assign rd_data    = !data_ready ? '0 : (fifo_en ? q_head : h_data);

    assign ovr_set = push_valid && (fifo_en ? (q_full && !fifo_clr)
                                            : (h_ready && !rd_en));

    always_ff @(posedge clk) begin
        if (rst)          overrun <= 1'b0;
        else if (ovr_set) overrun <= 1'b1;
        else if (ovr_rd)  overrun <= 1'b0;
    end

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int unsigned DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       fifo_en,
    input logic                       fifo_clr,
    input logic                       push_valid,
    input logic                       rd_en,
    input logic                       ovr_rd,
    input logic [$clog2(DEPTH+1)-1:0] fill_level,
    input logic                       data_ready,
    input logic                       irq,
    input logic                       overrun
);
    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill_level <= DEPTH);

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_en && fill_level == DEPTH && push_valid && !rd_en && !fifo_clr
        |=> overrun && (!fifo_en || fill_level == DEPTH));

    // R4
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_en && fill_level == 0 && rd_en && !push_valid |=> fill_level == 0);

    // R6
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_en && fifo_clr |=> fill_level == 0 && !irq);

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun && !ovr_rd |=> overrun);

    // R5
    irq_ready_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> data_ready);

    // R11
    single_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> fill_level <= 1);

endmodule

bind rx_fifo_trig rxq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .fifo_clr   (fifo_clr),
    .push_valid (push_valid),
    .rd_en      (rd_en),
    .ovr_rd     (ovr_rd),
    .fill_level (fill_level),
    .data_ready (data_ready),
    .irq        (irq),
    .overrun    (overrun)
);

// File: tb/test_rx_fifo_trig.sv
`timescale 1ns/1ps
module test_rx_fifo_trig;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b1, fifo_clr = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       push_valid = 1'b0, rd_en = 1'b0, ovr_rd = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic [7:0] rd_data;
    logic       data_ready, irq, overrun;
    logic [4:0] fill_level;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    rx_fifo_trig i_rx_fifo_trig (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
        .trig_sel(trig_sel), .push_valid(push_valid), .push_data(push_data),
        .rd_en(rd_en), .ovr_rd(ovr_rd), .rd_data(rd_data),
        .data_ready(data_ready), .fill_level(fill_level), .irq(irq),
        .overrun(overrun)
    );

    typedef struct packed {
        logic       push;
        logic [7:0] data;
        logic       rd;
        logic [4:0] fill;
        logic       irq;
    } vec_t;

    // Queued mode, level select 1 (4 bytes)
    localparam vec_t VECS [12] = '{
        '{1'b1, 8'hA0, 1'b0, 5'd1, 1'b0},
        '{1'b1, 8'hA1, 1'b0, 5'd2, 1'b0},
        '{1'b1, 8'hA2, 1'b0, 5'd3, 1'b0},
        '{1'b1, 8'hA3, 1'b0, 5'd4, 1'b1},
        '{1'b1, 8'hA4, 1'b1, 5'd4, 1'b1},
        '{1'b0, 8'h00, 1'b1, 5'd3, 1'b0},
        '{1'b1, 8'hA5, 1'b0, 5'd4, 1'b1},
        '{1'b0, 8'h00, 1'b1, 5'd3, 1'b0},
        '{1'b0, 8'h00, 1'b1, 5'd2, 1'b0},
        '{1'b0, 8'h00, 1'b1, 5'd1, 1'b0},
        '{1'b0, 8'h00, 1'b1, 5'd0, 1'b0},
        '{1'b0, 8'h00, 1'b1, 5'd0, 1'b0}
    };

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive for one cycle; returns shortly after the active edge
    task automatic tick(logic p, logic [7:0] d, logic r);
        @(negedge clk);
        push_valid = p; push_data = d; rd_en = r;
        @(posedge clk);
        #2;
        push_valid = 1'b0; rd_en = 1'b0; fifo_clr = 1'b0; ovr_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R10 reset state
        chk("R10", "fill_level", fill_level, 0);
        chk("R10", "data_ready", data_ready, 0);
        chk("R10", "irq", irq, 0);
        chk("R10", "overrun", overrun, 0);
        chk("R10", "rd_data", rd_data, 0);

        // Table walk: R2 and R5 (level 4), R4 (empty read in last row)
        trig_sel = 2'd1;
        foreach (VECS[i]) begin
            tick(VECS[i].push, VECS[i].data, VECS[i].rd);
            chk("R2", "table fill_level", fill_level, VECS[i].fill);
            chk("R5", "table irq", irq, VECS[i].irq);
        end

        // R1 order
        tick(1'b1, 8'h11, 1'b0);
        tick(1'b1, 8'h22, 1'b0);
        tick(1'b1, 8'h33, 1'b0);
        chk("R1", "head 1", rd_data, 8'h11);
        tick(1'b0, 8'h00, 1'b1);
        chk("R1", "head 2", rd_data, 8'h22);
        tick(1'b0, 8'h00, 1'b1);
        chk("R1", "head 3", rd_data, 8'h33);
        tick(1'b0, 8'h00, 1'b1);
        chk("R1", "rd_data empty", rd_data, 0);

        // R4 empty read then push
        tick(1'b0, 8'h00, 1'b1);
        chk("R4", "fill after empty read", fill_level, 0);
        tick(1'b1, 8'h5A, 1'b0);
        chk("R4", "head after empty read", rd_data, 8'h5A);
        tick(1'b0, 8'h00, 1'b1);

        // R3 fill to 16, overflow push, R5 level 14
        trig_sel = 2'd3;
        for (int i = 0; i < 16; i++) begin
            tick(1'b1, 8'(i * 3 + 5), 1'b0);
            chk("R5", "irq level 14 fill", irq, (i + 1 >= 14) ? 1 : 0);
        end
        chk("R3", "overrun before", overrun, 0);
        tick(1'b1, 8'hEE, 1'b0);
        chk("R3", "fill after drop", fill_level, 16);
        chk("R3", "overrun set", overrun, 1);
        for (int i = 0; i < 16; i++) begin
            chk("R3", "kept data", rd_data, 8'(i * 3 + 5));
            tick(1'b0, 8'h00, 1'b1);
            chk("R5", "irq level 14 drain", irq, (15 - i >= 14) ? 1 : 0);
        end
        chk("R9", "overrun still set", overrun, 1);
        ovr_rd = 1'b1;
        tick(1'b0, 8'h00, 1'b0);
        chk("R9", "overrun cleared", overrun, 0);

        // R5 level 1 and level 8
        trig_sel = 2'd0;
        tick(1'b1, 8'h01, 1'b0);
        chk("R5", "irq level 1", irq, 1);
        trig_sel = 2'd2;
        for (int i = 1; i < 8; i++) begin
            #1 chk("R5", "irq level 8", irq, 0);
            tick(1'b1, 8'h02, 1'b0);
        end
        chk("R5", "irq level 8 reached", irq, 1);

        // R6 flush with a push in the same cycle
        fifo_clr = 1'b1;
        tick(1'b1, 8'h99, 1'b0);
        chk("R6", "fill after flush", fill_level, 0);
        chk("R6", "irq after flush", irq, 0);

        // R11 leave queued mode with data stored
        tick(1'b1, 8'h44, 1'b0);
        tick(1'b1, 8'h45, 1'b0);
        fifo_en = 1'b0;
        tick(1'b0, 8'h00, 1'b0);
        chk("R11", "fill in single mode", fill_level, 0);
        fifo_en = 1'b1;
        tick(1'b0, 8'h00, 1'b0);
        chk("R11", "fill after re-enable", fill_level, 0);

        // R7 / R8 single-buffer mode
        fifo_en = 1'b0;
        tick(1'b1, 8'h77, 1'b0);
        chk("R7", "ready", data_ready, 1);
        chk("R7", "rd_data", rd_data, 8'h77);
        chk("R7", "fill", fill_level, 1);
        chk("R7", "irq", irq, 1);
        tick(1'b1, 8'h88, 1'b0);
        chk("R8", "replaced data", rd_data, 8'h88);
        chk("R8", "overrun", overrun, 1);
        tick(1'b0, 8'h00, 1'b1);
        chk("R7", "ready cleared", data_ready, 0);
        chk("R7", "irq cleared", irq, 0);

        // R9 set wins over acknowledge
        tick(1'b1, 8'h10, 1'b0);
        ovr_rd = 1'b1;
        tick(1'b1, 8'h20, 1'b0);
        chk("R9", "set wins", overrun, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule